// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block is the timekeeping core of a real-time clock. A one-cycle enable pulse arrives once per second. On each pulse the block advances a time-of-day and calendar held as packed BCD bytes: seconds, minutes, hours in 24-hour form, day of week, date, month and year. A century flag sits beside the year. Each byte has the tens digit in its upper nibble and the units digit in its lower nibble.

Some control bits live in bytes that also hold counters. The seconds byte carries a stop bit that freezes the counter. The hours byte carries a century-enable bit and the century flag. A register port writes one byte per cycle, selected by a 3-bit index. All seven bytes are driven on outputs at all times, so a surrounding interface can take a snapshot of them in a single cycle.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the byte outputs hold the following values: seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01 and year 00. All control bits are clear.
- R2: Seconds (seconds byte bits 6:0) and minutes count in BCD from 00 to 59 and wrap to 00. Each wrap carries into the next field. Hours (hours byte bits 5:0) count 00 to 23 and wrap to 00. BCD digit carries work as expected, so 09 is followed by 10.
- R3: When the time passes 23:59:59 into 00:00:00, the day of week (bits 2:0) advances by one, and 07 wraps to 01. It does so without regard to the date.
- R4: At midnight the date wraps to 01 after the last day of the month, and the month then advances. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the BCD year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R5: Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00. On that year wrap, the century flag (hours bit 6) toggles only when century enable (hours bit 7) is 1.
- R6: While seconds bit 7 is 1, pulses are ignored and every byte holds its value. While the bit is 0, the counter advances once per pulse.
- R7: A write takes effect at the next clock edge. In a cycle that has both a write and a pulse, the pulse is dropped, so no field other than the written byte changes.
- R8: Write index 0 to 6 selects seconds, minutes, hours, day of week, date, month and year, in that order. Written bits are kept under these masks: seconds FF, minutes 7F, hours FF, day of week 07, date 3F, month 1F, year FF. Masked-off bits read 0. A write to index 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Byte write strobe |
| wr_idx | input | 3 | Byte index for the write |
| wr_data | input | 8 | Write data |
| sec_q | output | 8 | Stop bit and BCD seconds |
| min_q | output | 8 | BCD minutes |
| hour_q | output | 8 | Century enable, century flag and BCD hours |
| dow_q | output | 8 | Day of week |
| date_q | output | 8 | BCD date |
| month_q | output | 8 | BCD month |
| year_q | output | 8 | BCD year |

## Verification
The range assertions assume that every written byte already holds a legal BCD value within its field's range. Out-of-range writes are not sanitised, so an illegal date written in would trip them. The stimulus therefore writes only legal values, even when it tests masking: bits above a field's mask are set, but the bits that remain form a valid value. The hold and write-priority properties make no assumption about how often pulses arrive. The stimulus pulses back to back as well as in isolated cycles.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] dow_q,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] year_q
);

  logic [7:0] r_sec, r_min, r_hour, r_dow, r_date, r_mon, r_year;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic step, sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap, yr_wrap, leap;
  logic [7:0] last_date, hr_next;

  assign step     = tick & ~r_sec[7] & ~wr_en;
  assign sec_wrap = r_sec[6:0] == 7'h59;
  assign min_wrap = r_min == 8'h59;
  assign hr_wrap  = r_hour[5:0] == 6'h23;
  assign mon_wrap = r_mon == 8'h12;
  assign yr_wrap  = r_year == 8'h99;
  assign leap     = r_year[4] ? (r_year[3:0] == 4'd2 || r_year[3:0] == 4'd6)
                              : (r_year[3:0] == 4'd0 || r_year[3:0] == 4'd4 || r_year[3:0] == 4'd8);
  assign hr_next  = bcd_inc({2'b00, r_hour[5:0]});

  always_comb begin
    case (r_mon)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end
  assign date_wrap = r_date == last_date;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_sec <= 8'h00; r_min <= 8'h00; r_hour <= 8'h00; r_dow <= 8'h01;
      r_date <= 8'h01; r_mon <= 8'h01; r_year <= 8'h00;
    end else if (wr_en) begin
      case (wr_idx)
        3'd0: r_sec  <= wr_data;
        3'd1: r_min  <= wr_data & 8'h7F;
        3'd2: r_hour <= wr_data;
        3'd3: r_dow  <= wr_data & 8'h07;
        3'd4: r_date <= wr_data & 8'h3F;
        3'd5: r_mon  <= wr_data & 8'h1F;
        3'd6: r_year <= wr_data;
        default: ;
      endcase
    end else if (step) begin
      r_sec <= sec_wrap ? 8'h00 : bcd_inc(r_sec);
      if (sec_wrap) begin
        r_min <= min_wrap ? 8'h00 : bcd_inc(r_min);
        if (min_wrap) begin
          r_hour[5:0] <= hr_wrap ? 6'h00 : hr_next[5:0];
          if (hr_wrap) begin
            r_dow  <= (r_dow == 8'h07) ? 8'h01 : r_dow + 8'h01;
            r_date <= date_wrap ? 8'h01 : bcd_inc(r_date);
            if (date_wrap) begin
              r_mon <= mon_wrap ? 8'h01 : bcd_inc(r_mon);
              if (mon_wrap) begin
                r_year <= yr_wrap ? 8'h00 : bcd_inc(r_year);
                if (yr_wrap && r_hour[7]) r_hour[6] <= ~r_hour[6];
              end
            end
          end
        end
      end
    end
  end

  assign sec_q = r_sec;   assign min_q = r_min;   assign hour_q = r_hour;
  assign dow_q = r_dow;   assign date_q = r_date; assign month_q = r_mon;
  assign year_q = r_year;

  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_sec[6:0] <= 7'h59) && (r_sec[3:0] <= 4'd9) && (r_min <= 8'h59) && (r_hour[5:0] <= 6'h23));
  // R3
  dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_dow >= 8'h01) && (r_dow <= 8'h07));
  // R4
  date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_date != 8'h00) && (r_date <= 8'h31) && (r_date[3:0] <= 4'd9));
  // R6
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_sec[7] && !wr_en) |=> ($stable(r_sec) && $stable(r_min) && $stable(r_hour)
                              && $stable(r_date) && $stable(r_year)));
  // R7
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd0) |=> (r_sec == $past(wr_data) && $stable(r_min)));
  // R5
  century_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !r_hour[7]) |=> $stable(r_hour[6]));

endmodule

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_idx = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .dow_q(dow_q),
    .date_q(date_q), .month_q(month_q), .year_q(year_q));

  // {sec,min,hour,dow,date,month,year} before one pulse, then after it
  localparam logic [111:0] VEC [NV] = '{
    {56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00},  // R2 plain step
    {56'h59_34_12_02_10_03_20, 56'h00_35_12_02_10_03_20},  // R2 sec wrap
    {56'h09_00_00_01_01_01_00, 56'h10_00_00_01_01_01_00},  // R2 digit carry
    {56'h59_59_09_05_10_03_20, 56'h00_00_10_05_10_03_20},  // R2 hour carry
    {56'h59_59_23_07_15_06_24, 56'h00_00_00_01_16_06_24},  // R3 dow wrap
    {56'h59_59_23_03_30_04_24, 56'h00_00_00_04_01_05_24},  // R4 30-day month
    {56'h59_59_23_03_31_01_24, 56'h00_00_00_04_01_02_24},  // R4 31-day month
    {56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},  // R4 non-leap
    {56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24},  // R4 leap
    {56'h59_59_23_02_29_02_24, 56'h00_00_00_03_01_03_24},  // R4 leap end
    {56'h59_59_23_02_28_02_12, 56'h00_00_00_03_29_02_12},  // R4 leap odd tens
    {56'h59_59_23_02_28_02_10, 56'h00_00_00_03_01_03_10},  // R4 non-leap 10
    {56'h59_59_A3_06_31_12_99, 56'h00_00_C0_07_01_01_00},  // R5 century toggles
    {56'h59_59_23_06_31_12_99, 56'h00_00_00_07_01_01_00}   // R5 century disabled
  };

  function automatic logic [55:0] snap();
    return {sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q};
  endfunction

  task automatic check(input string tag, input logic [55:0] got, input logic [55:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic load(input logic [55:0] s);
    for (int b = 0; b < 7; b++) wr(3'(b), s[55-8*b -: 8]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", snap(), 56'h00_00_00_01_01_01_00);

    for (int v = 0; v < NV; v++) begin
      load(VEC[v][111:56]);
      pulse();
      check($sformatf("R2-5 vector %0d", v), snap(), VEC[v][55:0]);
    end

    // R6 stop bit holds all bytes
    load(56'h85_59_23_07_31_12_99);
    pulse(); pulse();
    check("R6 hold", snap(), 56'h85_59_23_07_31_12_99);
    wr(3'd0, 8'h05);
    pulse();
    check("R6 run", snap(), 56'h06_59_23_07_31_12_99);

    // R2 back-to-back pulses
    load(56'h58_59_23_01_01_01_00);
    @(negedge clk); tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    check("R2 back-to-back", snap(), 56'h01_00_00_02_02_01_00);

    // R7 write beats a pulse in the same cycle
    load(56'h59_59_23_01_01_01_00);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_idx = 3'd0; wr_data = 8'h30;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R7 priority", snap(), 56'h30_59_23_01_01_01_00);

    // R8 masks and ignored index 7
    wr(3'd1, 8'hD9); wr(3'd3, 8'hF5); wr(3'd4, 8'hC9); wr(3'd5, 8'hE9);
    check("R8 masks", snap(), 56'h30_59_23_05_09_09_00);
    wr(3'd7, 8'hFF);
    check("R8 index 7", snap(), 56'h30_59_23_05_09_09_00);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 re-reset", snap(), 56'h00_00_00_01_01_01_00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule